// File: doc/BRIEF.md
# Paged Address Translation and Protection Checker

This block is the translation and protection stage of a memory management unit for a 16-bit processor with three privilege modes. Each access presents a 16-bit virtual address, the requesting mode, an instruction/data space select and an access type. The top three address bits pick one of eight pages. The block looks up the matching page descriptor and page base, checks the access against the descriptor's length, growth direction and access-control code, and forms an 18-bit or 22-bit physical address. One cycle later it reports a physical address, any abort flags and a management-trap request.

Pages whose access-control code asks for traps record accesses in two tracking bits of their descriptor. One bit records any access and the other records writes. The trap decision uses the global control register as it stood before the current clock edge. A control write in the same cycle as an access therefore does not affect that access. The descriptor, base and control registers sit in a small internal array. A word-addressed bus port reads and writes them.

Top module: `pgx_xlate`

## Requirements
- R1: With translation on (control bit 0 set), the physical address is base*64 plus virtual bits 12:0. When control bit 2 is set the result is 22 bits wide. When bit 2 is clear it is truncated to 18 bits. The base comes from the register selected by {mode, space, virtual bits 15:13}.
- R2: With translation off, no abort or trap is reported. The physical address equals the virtual address, except that page 7 maps to the top 8 KB of physical space. That region starts at 0x3FE000 when control bit 2 is set and at 0x3E000 when it is clear.
- R3: Descriptor bits 2:0 hold the access-control code. Code 0 and the odd codes 1, 3, 5 and 7 are non-resident: any access raises only the non-resident abort, with no length or read-only abort.
- R4: When descriptor bit 3 is clear (upward page), a length abort is raised when the block number (virtual bits 12:6) exceeds the length field (descriptor bits 14:8). A block equal to the length field is legal.
- R5: When descriptor bit 3 is set (downward page), a length abort is raised when the block number is below the length field. A block equal to the length field is legal.
- R6: Access type 0 is a read, 1 a write, 2 an instruction fetch and 3 is treated as a read. Code 2 is read-only: a write raises the read-only abort, while reads and fetches pass. Codes 4 and 6 allow all access types.
- R7: A non-aborted access of any type to a code-4 page raises the trap request when control bit 1 (trap enable) is set. No trap is raised when bit 1 is clear, when the access aborts, or for any other code.
- R8: The trap decision uses the control value from before the clock edge. An access in the same cycle as a control write that sets trap enable does not trap. The next access does.
- R9: A non-aborted access to a code-4 page sets descriptor bit 7, and a write also sets bit 6. Aborted accesses and accesses to pages with any other code leave both bits unchanged.
- R10: A bus write to a descriptor stores the data masked with 0x7F0F, so bits 7:6 are cleared. A write in the same cycle takes priority over a tracking update.
- R11: The result valid output follows the access valid input with exactly one cycle of latency.
- R12: Bus address bit 7 set selects the control register (bits 2:0, read back zero-extended). Otherwise bits 6:5 give the mode, bit 4 the data space, bit 3 selects base (1) or descriptor (0), and bits 2:0 give the page. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| acc_valid | input | 1 | Access request valid |
| acc_va | input | 16 | Virtual address |
| acc_mode | input | 2 | Mode: 0 kernel, 1 supervisor, 3 user |
| acc_dspace | input | 1 | 1 selects data space registers |
| acc_type | input | 2 | Access type code |
| res_valid | output | 1 | Result valid |
| res_pa | output | 22 | Physical address |
| res_abort_nr | output | 1 | Non-resident abort |
| res_abort_len | output | 1 | Length abort |
| res_abort_ro | output | 1 | Read-only abort |
| res_trap | output | 1 | Management trap request |

## Verification
The hardest situation to reach is an access landing in the same cycle as a control write that changes trap enable. Random traffic almost never lines these two up. The stimulus therefore drives the bus write and a code-4 access together on purpose, then repeats the access on the next cycle. Tracking-bit behaviour is hard to see because it only shows up on a later descriptor read. The stimulus reads descriptors back after trap-page reads, writes, and length-aborted accesses. It also issues a descriptor rewrite together with an access to the same page. A behavioural model then runs several thousand random cycles and compares every output on every clock.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    localparam int VA_W      = 16;
    localparam int PA_W      = 22;
    localparam int PA_NARROW = 18;
    localparam int PAGE_W    = 3;
    localparam int OFF_W     = VA_W - PAGE_W;
    localparam int CLICK_W   = 6;
    localparam int BLK_W     = OFF_W - CLICK_W;
    localparam int MODE_W    = 2;
    localparam int IDX_W     = MODE_W + 1 + PAGE_W;
    localparam int NREG      = 1 << IDX_W;
    localparam logic [15:0] DESC_MASK = 16'h7F0F;

    typedef enum logic [1:0] {
        ACC_RD  = 2'd0,
        ACC_WR  = 2'd1,
        ACC_IF  = 2'd2,
        ACC_RSV = 2'd3
    } acc_e;

    typedef enum logic [2:0] {
        ACF_NONE = 3'd0,
        ACF_RO   = 3'd2,
        ACF_RWT  = 3'd4,
        ACF_RW   = 3'd6
    } acf_e;

    typedef struct packed {
        logic wide;
        logic trap_en;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic [PA_W-1:0] pa;
        logic            nr;
        logic            len;
        logic            ro;
        logic            trap;
        logic            touch;
        logic            wrote;
    } xres_t;

    function automatic logic acf_resident(input logic [2:0] code);
        return (code == ACF_RO) || (code == ACF_RWT) || (code == ACF_RW);
    endfunction
endpackage

// File: rtl/pgx_regfile.sv
module pgx_regfile
    import pgx_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [IDX_W-1:0] acc_idx,
    output logic [DW-1:0]    acc_desc,
    output logic [DW-1:0]    acc_base,
    output ctl_t             ctl,
    input  logic             upd_touch,
    input  logic             upd_wrote
);
    logic [DW-1:0] desc_q [NREG];
    logic [DW-1:0] base_q [NREG];
    logic [IDX_W-1:0] bus_idx;
    logic sel_ctl, sel_base;

    assign bus_idx  = {addr[6:4], addr[2:0]};
    assign sel_ctl  = addr[7];
    assign sel_base = addr[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
            for (int i = 0; i < NREG; i++) begin
                desc_q[i] <= '0;
                base_q[i] <= '0;
            end
        end else begin
            if (upd_touch) desc_q[acc_idx][7] <= 1'b1;
            if (upd_wrote) desc_q[acc_idx][6] <= 1'b1;
            if (we) begin
                if (sel_ctl)       ctl              <= ctl_t'(wdata[2:0]);
                else if (sel_base) base_q[bus_idx]  <= wdata;
                else               desc_q[bus_idx]  <= wdata & DESC_MASK;
            end
        end
    end

    always_comb begin
        if (sel_ctl)       rdata = {{(DW-3){1'b0}}, ctl};
        else if (sel_base) rdata = base_q[bus_idx];
        else               rdata = desc_q[bus_idx];
    end

    assign acc_desc = desc_q[acc_idx];
    assign acc_base = base_q[acc_idx];

    // R10
    desc_wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (we && !sel_ctl && !sel_base) |=> (desc_q[$past(bus_idx)][7:6] == 2'b00));
endmodule

// File: rtl/pgx_check.sv
module pgx_check
    import pgx_pkg::*;
(
    input  logic            valid,
    input  logic [VA_W-1:0] va,
    input  acc_e            kind,
    input  logic [15:0]     desc,
    input  logic [15:0]     base,
    input  ctl_t            ctl,
    output xres_t           res
);
    logic [BLK_W-1:0] blk, plf;
    logic [2:0]       acf;
    logic             down, ok;
    logic [PA_W-1:0]  off, sum, iopage;

    assign blk  = va[OFF_W-1:CLICK_W];
    assign plf  = desc[14:8];
    assign down = desc[3];
    assign acf  = desc[2:0];
    assign off  = {{(PA_W-OFF_W){1'b0}}, va[OFF_W-1:0]};
    assign sum  = {base, {CLICK_W{1'b0}}} + off;
    assign iopage = ctl.wide ? {{(PA_W-OFF_W){1'b1}}, va[OFF_W-1:0]}
                             : {{(PA_W-PA_NARROW){1'b0}}, {(PA_NARROW-OFF_W){1'b1}}, va[OFF_W-1:0]};

    always_comb begin
        res = '0;
        ok  = 1'b0;
        if (ctl.en) begin
            res.pa  = ctl.wide ? sum : {{(PA_W-PA_NARROW){1'b0}}, sum[PA_NARROW-1:0]};
            res.nr  = valid && !acf_resident(acf);
            res.len = valid && !res.nr && (down ? (blk < plf) : (blk > plf));
            res.ro  = valid && !res.nr && (acf == ACF_RO) && (kind == ACC_WR);
            ok      = valid && !res.nr && !res.len && !res.ro && (acf == ACF_RWT);
            res.touch = ok;
            res.wrote = ok && (kind == ACC_WR);
            res.trap  = ok && ctl.trap_en;
        end else if (va[VA_W-1:OFF_W] == {PAGE_W{1'b1}}) begin
            res.pa = iopage;
        end else begin
            res.pa = {{(PA_W-VA_W){1'b0}}, va};
        end
    end
endmodule

// File: rtl/pgx_xlate.sv
module pgx_xlate
    import pgx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [VA_W-1:0]   acc_va,
    input  logic [MODE_W-1:0] acc_mode,
    input  logic              acc_dspace,
    input  logic [1:0]        acc_type,
    output logic              res_valid,
    output logic [PA_W-1:0]   res_pa,
    output logic              res_abort_nr,
    output logic              res_abort_len,
    output logic              res_abort_ro,
    output logic              res_trap
);
    logic [IDX_W-1:0]  acc_idx;
    logic [DATA_W-1:0] cur_desc, cur_base;
    ctl_t              ctl;
    xres_t             xr;

    assign acc_idx = {acc_mode, acc_dspace, acc_va[VA_W-1:OFF_W]};

    pgx_regfile #(.AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .acc_idx(acc_idx), .acc_desc(cur_desc),
        .acc_base(cur_base), .ctl(ctl),
        .upd_touch(xr.touch), .upd_wrote(xr.wrote)
    );

    pgx_check u_chk (
        .valid(acc_valid), .va(acc_va), .kind(acc_e'(acc_type)),
        .desc(cur_desc), .base(cur_base), .ctl(ctl), .res(xr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_pa        <= '0;
            res_abort_nr  <= 1'b0;
            res_abort_len <= 1'b0;
            res_abort_ro  <= 1'b0;
            res_trap      <= 1'b0;
        end else begin
            res_valid     <= acc_valid;
            res_pa        <= xr.pa;
            res_abort_nr  <= xr.nr;
            res_abort_len <= xr.len;
            res_abort_ro  <= xr.ro;
            res_trap      <= xr.trap;
        end
    end

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid);
    // R7
    trap_excl_chk: assert property (@(posedge clk) disable iff (rst)
        res_trap |-> !(res_abort_nr || res_abort_len || res_abort_ro));
    // R3
    nr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        res_abort_nr |-> !(res_abort_len || res_abort_ro));
    // R2
    off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !reg_rdata[0] && reg_addr[7]) |=>
            !(res_abort_nr || res_abort_len || res_abort_ro || res_trap));
endmodule

// File: tb/pgx_xlate_bench.sv
`timescale 1ns/1ps
module pgx_xlate_bench;
    logic clk = 0, rst = 1;
    logic reg_we = 0;
    logic [7:0] reg_addr = 0;
    logic [15:0] reg_wdata = 0, reg_rdata;
    logic acc_valid = 0;
    logic [15:0] acc_va = 0;
    logic [1:0] acc_mode = 0, acc_type = 0;
    logic acc_dspace = 0;
    logic res_valid, res_abort_nr, res_abort_len, res_abort_ro, res_trap;
    logic [21:0] res_pa;

    int checks = 0, failures = 0;
    int m_desc[64], m_base[64], m_ctl;
    int e_valid, e_pa, e_nr, e_len, e_ro, e_trap;
    string t_pa, t_len, t_trap;

    always #4 clk = ~clk;

    pgx_xlate u_pgx_xlate (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_va(acc_va), .acc_mode(acc_mode), .acc_dspace(acc_dspace),
        .acc_type(acc_type), .res_valid(res_valid), .res_pa(res_pa),
        .res_abort_nr(res_abort_nr), .res_abort_len(res_abort_len),
        .res_abort_ro(res_abort_ro), .res_trap(res_trap)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int model_rd(input int a);
        int i;
        i = ((a >> 4) & 7) * 8 + (a & 7);
        if (a & 'h80) return m_ctl & 7;
        if (a & 8) return m_base[i];
        return m_desc[i];
    endfunction

    // one clock: predict from pre-edge model state, update model, compare after edge
    task automatic cycle();
        int i, d, acf, blk, plf, dn, nr, len, ro, ok, off, wa;
        bit ctlw;
        e_valid = acc_valid; e_nr = 0; e_len = 0; e_ro = 0; e_trap = 0;
        i = acc_mode * 16 + acc_dspace * 8 + acc_va[15:13];
        d = m_desc[i]; acf = d & 7; blk = (acc_va >> 6) & 'h7F; plf = (d >> 8) & 'h7F; dn = (d >> 3) & 1;
        off = acc_va & 'h1FFF;
        ctlw = reg_we && reg_addr[7];
        t_pa = (m_ctl & 1) ? "R1" : "R2";
        t_len = dn ? "R5" : "R4";
        t_trap = ctlw ? "R8" : "R7";
        if (m_ctl & 1) begin
            e_pa = m_base[i] * 64 + off;
            e_pa = (m_ctl & 4) ? (e_pa & 'h3FFFFF) : (e_pa & 'h3FFFF);
            if (acc_valid) begin
                nr = !(acf == 2 || acf == 4 || acf == 6);
                len = !nr && (dn ? (blk < plf) : (blk > plf));
                ro = !nr && acf == 2 && acc_type == 1;
                ok = !nr && !len && !ro && acf == 4;
                e_nr = nr; e_len = len; e_ro = ro;
                e_trap = ok && ((m_ctl >> 1) & 1);
                if (ok) begin
                    m_desc[i] = m_desc[i] | 'h80;
                    if (acc_type == 1) m_desc[i] = m_desc[i] | 'h40;
                end
            end
        end else if (acc_va[15:13] == 7) begin
            e_pa = ((m_ctl & 4) ? 'h3FE000 : 'h3E000) | off;
        end else begin
            e_pa = acc_va;
        end
        if (reg_we) begin
            wa = ((reg_addr >> 4) & 7) * 8 + (reg_addr & 7);
            if (reg_addr[7]) m_ctl = reg_wdata & 7;
            else if (reg_addr[3]) m_base[wa] = reg_wdata;
            else m_desc[wa] = reg_wdata & 'h7F0F;
        end
        @(posedge clk);
        @(negedge clk);
        chk("R11", "res_valid", res_valid, e_valid);
        if (e_valid) begin
            chk(t_pa, "res_pa", res_pa, e_pa);
            chk("R3", "abort_nr", res_abort_nr, e_nr);
            chk(t_len, "abort_len", res_abort_len, e_len);
            chk("R6", "abort_ro", res_abort_ro, e_ro);
            chk(t_trap, "trap", res_trap, e_trap);
        end
        chk("R12", "rdata", reg_rdata, model_rd(reg_addr));
    endtask

    task automatic idle();
        reg_we = 0; acc_valid = 0;
    endtask

    task automatic wr(input int a, input int v);
        idle(); reg_we = 1; reg_addr = a[7:0]; reg_wdata = v[15:0];
        cycle(); reg_we = 0;
    endtask

    task automatic acc(input int mode, input int ds, input int va, input int ty);
        idle(); acc_valid = 1; acc_mode = mode[1:0]; acc_dspace = ds[0];
        acc_va = va[15:0]; acc_type = ty[1:0];
        cycle(); acc_valid = 0;
    endtask

    task automatic rd(input int a, input string tag, input int exp);
        idle(); reg_addr = a[7:0]; #1;
        chk(tag, "readback", reg_rdata, exp);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int k = 0; k < 64; k++) begin m_desc[k] = 0; m_base[k] = 0; end
        m_ctl = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // reset state (R12, R11)
        chk("R11", "reset res_valid", res_valid, 0);
        rd('h80, "R12", 0); rd('h05, "R12", 0); rd('h3D, "R12", 0);

        // R2: translation off
        acc(0, 0, 'h6123, 0); acc(0, 0, 'hE456, 1);
        wr('h80, 4); acc(0, 0, 'hE456, 2); acc(3, 1, 'h1FFF, 1);

        // kernel I-space pages
        wr('h08, 'h0000); wr('h00, 'h7F06);           // page0 full RW
        wr('h09, 'h1234); wr('h01, 'h0A06);           // page1 up, len 10
        wr('h0A, 'h0200); wr('h02, 'h640E);           // page2 down, len 100
        wr('h03, 'h7F00);                             // page3 non-resident
        wr('h0C, 'h0400); wr('h04, 'h7F02);           // page4 read-only
        wr('h0D, 'h0500); wr('h05, 'h7F04);           // page5 trap page
        wr('h06, 'h7F05);                             // page6 reserved code
        wr('h0F, 'hFF80); wr('h07, 'h7F06);           // page7 high base
        rd('h05, "R10", 'h7F04);
        wr('h80, 5);                                  // on, wide, no traps
        acc(0, 0, 'h0ABC, 0);                                     // R1
        acc(0, 0, 'hFFFE, 1);                                     // R1 wide top
        acc(0, 0, 'h2000 | (10 << 6) | 3, 0);                     // R4 boundary ok
        acc(0, 0, 'h2000 | (11 << 6), 0);                         // R4 abort
        acc(0, 0, 'h4000 | (100 << 6), 1);                        // R5 boundary ok
        acc(0, 0, 'h4000 | (99 << 6), 2);                         // R5 abort
        acc(0, 0, 'h6000, 2); acc(0, 0, 'hC000, 0);               // R3
        acc(0, 0, 'h8000, 0); acc(0, 0, 'h8000, 2);
        acc(0, 0, 'h8000, 3); acc(0, 0, 'h8000, 1);               // R6
        acc(0, 0, 'hA000, 0);                                     // R7 no trap_en
        wr('h80, 1); acc(0, 0, 'hFFFE, 0);                        // R1 narrow
        wr('h80, 4); acc(0, 0, 'hE010, 0); wr('h80, 5);           // R2 back off

        // R8: same-cycle control write does not affect trap decision
        wr('h05, 'h7F04);
        idle(); reg_we = 1; reg_addr = 'h80; reg_wdata = 7;
        acc_valid = 1; acc_mode = 0; acc_dspace = 0; acc_va = 'hA040; acc_type = 0;
        cycle(); idle();
        acc(0, 0, 'hA040, 2);                                     // R7 fetch traps
        // R9 tracking bits
        wr('h05, 'h7F04); rd('h05, "R10", 'h7F04);
        acc(0, 0, 'hA000, 0); rd('h05, "R9", 'h7F84);
        acc(0, 0, 'hA000, 1); rd('h05, "R9", 'h7FC4);
        wr('h05, 'h05FF); rd('h05, "R10", 'h050F);                // mask, clear
        wr('h05, 'h0504);
        acc(0, 0, 'hA000 | (20 << 6), 1); rd('h05, "R9", 'h0504); // aborted: no change
        acc(0, 0, 'h0100, 1); rd('h00, "R9", 'h7F06);             // other code
        // R10: descriptor write wins over same-cycle tracking update
        idle(); reg_we = 1; reg_addr = 'h05; reg_wdata = 'h7F04;
        acc_valid = 1; acc_mode = 0; acc_dspace = 0; acc_va = 'hA000; acc_type = 1;
        cycle(); idle(); rd('h05, "R10", 'h7F04);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle();
            r = $urandom % 100;
            if (r < 12) begin
                reg_we = 1;
                reg_addr = (r < 1) ? 8'h80 : 8'($urandom % 128);
                reg_wdata = (r < 1) ? 16'(1 | ($urandom % 8)) : 16'($urandom);
                if (reg_addr[3] == 0 && !reg_addr[7] && ($urandom % 2))
                    reg_wdata = {1'b0, 7'($urandom), 4'h0, 1'($urandom), 3'($urandom % 2 ? 4 : 6)};
            end else begin
                reg_addr = 8'($urandom);
            end
            if ($urandom % 4 != 0) begin
                acc_valid = 1; acc_mode = 2'($urandom); acc_dspace = 1'($urandom);
                acc_va = 16'($urandom); acc_type = 2'($urandom);
            end
            cycle();
        end
        idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule